// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block answers as a slave on a two-wire serial bus (a clock line and an open-drain data line) and fronts a 256-byte memory array. The array is held in registers and models non-volatile storage. Both bus lines are sampled with the system clock through short synchronizers, and edges are found on the sampled copies. A START or STOP condition is a data-line edge while the clock line is high. The block pulls the data line low through `sda_oe` to acknowledge and to send read data. It never drives the line high.

The first byte after a START carries a 7-bit device address, made of the type code `1010` followed by the three `dev_sel` strap inputs, plus a direction bit (1 = read, 0 = write). A write places the next byte in the word pointer. Each data byte after that lands in a 16-byte page buffer at the pointer's low four bits. Only the low four bits advance, so the pointer wraps inside the page. A STOP then commits the buffered bytes to the array in one cycle and starts a programming timer of `PROG_CYCLES` clocks. While the timer runs, the block does not acknowledge its address, so a master can poll for completion. A read sends the byte at the pointer and increments the full 8-bit pointer after each byte, wrapping from 0xFF to 0x00. A master NACK ends the read. While `lock_hi` is high, bytes aimed at 0x80..0xFF are acknowledged but are not stored.

The controller states are IDLE, DEV (shift in the address byte), DEV_ACK, WORD (shift in the word address), WORD_ACK, WDATA (shift in a data byte), WDATA_ACK, RDATA (shift out a byte), RACK (sample the master's acknowledge) and SKIP (stay silent until the next START). A START moves any state to DEV and drops buffered bytes. A STOP moves any state to IDLE and commits pending bytes. DEV goes to DEV_ACK on an address match while not busy, and to SKIP otherwise. DEV_ACK goes to RDATA for a read and to WORD for a write. WORD_ACK and WDATA_ACK go to WDATA. RDATA goes to RACK after eight bits. RACK goes back to RDATA on an ACK and to SKIP on a NACK.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and every array cell reads 0xFF.
- R2: Only an address byte whose upper seven bits equal `1010` followed by `dev_sel[2:0]` is acknowledged. Any other address gets no acknowledge, and the block stays silent for the rest of that transaction.
- R3: In a write, the word-address byte and each data byte are acknowledged. After STOP, each data byte is found at the pointer value it was received at.
- R4: During a write, only the low four pointer bits increment, wrapping within the 16-byte page. A seventeenth or later byte overwrites the earlier byte at the same offset, and the page bits never change while a write is pending.
- R5: A random read (write of the word address, repeated START, read address) returns the byte at that word. A read that starts without a word address returns the byte at the current pointer.
- R6: A sequential read returns successive bytes, wrapping from 0xFF to 0x00. After a master NACK the block releases the data line.
- R7: A STOP that ends a write carrying at least one data byte starts a busy window of `PROG_CYCLES` clocks. During that window the block does not acknowledge its address, and it acknowledges again once the window ends.
- R8: While `lock_hi` is 1, data bytes aimed at 0x80..0xFF are acknowledged but leave the array unchanged. Bytes aimed at 0x00..0x7F are still stored.
- R9: The block never pulls the data line while the master is sending address, word or data bits.
- R10: `sda_oe` changes only while the clock line is low, or right after a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_sel | input | 3 | Strap bits that form the low part of the device address |
| lock_hi | input | 1 | 1 protects the upper half of the array from writes |

## Verification
Two functions can meet in the same cycle: the end of the programming window and the address decision of a polling master. After each write the bench polls repeatedly, so one poll is bound to land near the timer's expiry. The bench's model records when the STOP occurred. Each poll's acknowledge is judged against that model, and polls that fall within a small margin of the boundary are left unjudged. A second overlap is a data-line change from the block against a clock-high period or a master-driven bit. Per-clock monitors catch both.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } ee_state_t;

    localparam int DEV_ADDR_BITS = 7;

endpackage

// File: rtl/i2cee_line_sync.sv
module i2cee_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b1;
        else        last <= chain[STAGES-1];
    end

    assign q    = chain[STAGES-1];
    assign rise = q & ~last;
    assign fall = ~q & last;

endmodule

// File: rtl/i2cee_prog_timer.sv
module i2cee_prog_timer #(
    parameter int CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            left <= '0;
        else if (kick)         left <= CW'(CYCLES);
        else if (left != '0)   left <= left - CW'(1);
    end

    assign busy = (left != '0);

    // R7
    kick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> !busy);

endmodule

// File: rtl/i2cee_array.sv
module i2cee_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       commit,
    input  logic [ADDR_W-PAGE_W-1:0]                   page_idx,
    input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0]         page_data,
    input  logic [(1<<PAGE_W)-1:0]                     page_mask,
    input  logic [ADDR_W-1:0]                          rd_addr,
    output logic [DATA_W-1:0]                          rd_data
);

    localparam int WORDS      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) cells[w] <= '1;
        end else if (commit) begin
            for (int b = 0; b < PAGE_BYTES; b++) begin
                if (page_mask[b]) cells[{page_idx, PAGE_W'(b)}] <= page_data[b];
            end
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import i2cee_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 8,
    parameter int          PAGE_W      = 4,
    parameter int          SYNC_STAGES = 2,
    parameter int          PROG_CYCLES = 1000000,
    parameter logic [3:0]  TYPE_CODE   = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] dev_sel,
    input  logic       lock_hi
);

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PAGE_IDX_W = ADDR_W - PAGE_W;
    localparam int CNT_W      = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic scl_q, scl_rise, scl_fall;
    logic sda_q, sda_rise, sda_fall;
    logic ev_start, ev_stop;

    ee_state_t                         state;
    logic [CNT_W-1:0]                  bit_cnt;
    logic                              byte_done;
    logic [DATA_W-1:0]                 rx_sr;
    logic [DATA_W-1:0]                 tx_sr;
    logic                              rd_mode;
    logic                              m_ack;
    logic [ADDR_W-1:0]                 word_ptr;
    logic [ADDR_W-1:0]                 page_next;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] pbuf;
    logic [PAGE_BYTES-1:0]             pmask;
    logic                              wr_pend;
    logic                              commit;
    logic                              busy;
    logic                              addr_hit;
    logic                              guarded;
    logic [DATA_W-1:0]                 rd_data;

    i2cee_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (scl_i),
        .q    (scl_q),
        .rise (scl_rise),
        .fall (scl_fall)
    );

    i2cee_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sda_i),
        .q    (sda_q),
        .rise (sda_rise),
        .fall (sda_fall)
    );

    i2cee_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .kick (commit),
        .busy (busy)
    );

    i2cee_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .page_idx (word_ptr[ADDR_W-1:PAGE_W]),
        .page_data(pbuf),
        .page_mask(pmask),
        .rd_addr  (word_ptr),
        .rd_data  (rd_data)
    );

    assign ev_start  = scl_q & sda_fall;
    assign ev_stop   = scl_q & sda_rise;
    assign addr_hit  = (rx_sr[DATA_W-1:DATA_W-DEV_ADDR_BITS] == {TYPE_CODE, dev_sel});
    assign guarded   = lock_hi & word_ptr[ADDR_W-1];
    assign page_next = {word_ptr[ADDR_W-1:PAGE_W], word_ptr[PAGE_W-1:0] + PAGE_W'(1)};

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            rx_sr     <= '0;
            tx_sr     <= '1;
            rd_mode   <= 1'b0;
            m_ack     <= 1'b0;
            word_ptr  <= '0;
            pbuf      <= '0;
            pmask     <= '0;
            wr_pend   <= 1'b0;
            commit    <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (ev_start) begin
                state     <= ST_DEV;
                bit_cnt   <= '0;
                byte_done <= 1'b0;
                wr_pend   <= 1'b0;
                pmask     <= '0;
            end else if (ev_stop) begin
                state <= ST_IDLE;
                if (wr_pend) begin
                    commit  <= 1'b1;
                    wr_pend <= 1'b0;
                end
            end else begin
                unique case (state)
                    ST_DEV, ST_WORD, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sr   <= {rx_sr[DATA_W-2:0], sda_q};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                            if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
                        end else if (scl_fall && byte_done) begin
                            byte_done <= 1'b0;
                            bit_cnt   <= '0;
                            if (state == ST_DEV) begin
                                if (addr_hit && !busy) begin
                                    rd_mode <= rx_sr[0];
                                    state   <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else if (state == ST_WORD) begin
                                word_ptr <= rx_sr[ADDR_W-1:0];
                                state    <= ST_WORD_ACK;
                            end else begin
                                pbuf[word_ptr[PAGE_W-1:0]] <= rx_sr;
                                if (!guarded) pmask[word_ptr[PAGE_W-1:0]] <= 1'b1;
                                wr_pend  <= 1'b1;
                                word_ptr <= page_next;
                                state    <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            if (rd_mode) begin
                                tx_sr    <= rd_data;
                                word_ptr <= word_ptr + ADDR_W'(1);
                                state    <= ST_RDATA;
                            end else begin
                                state <= ST_WORD;
                            end
                        end
                    end
                    ST_WORD_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) state <= ST_WDATA;
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            tx_sr   <= {tx_sr[DATA_W-2:0], 1'b1};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                            if (bit_cnt == LAST_BIT) begin
                                bit_cnt <= '0;
                                state   <= ST_RACK;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_q;
                        end else if (scl_fall) begin
                            if (m_ack) begin
                                tx_sr    <= rd_data;
                                word_ptr <= word_ptr + ADDR_W'(1);
                                state    <= ST_RDATA;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_IDLE, ST_SKIP: begin
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_WORD_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~tx_sr[DATA_W-1];
            default:                               sda_oe = 1'b0;
        endcase
    end

    // R7
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> state != ST_DEV_ACK);

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> $stable(word_ptr[ADDR_W-1:PAGE_W]));

    // R8
    lock_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_hi && word_ptr[ADDR_W-1] && state == ST_WDATA && scl_fall && byte_done
         && !ev_start && !ev_stop) |=> $stable(pmask));

    // R10
    sda_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_q && $past(scl_q) && !$past(ev_start) && !$past(ev_stop)) |-> $stable(sda_oe));

endmodule

// File: tb/tb_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_slave;

    localparam int         PROG = 1500;
    localparam int         Q    = 10;
    localparam logic [2:0] SEL  = 3'b101;
    localparam logic [7:0] DEVW = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEVR = {4'b1010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic lock = 1'b0;
    logic dut_oe;
    logic sda;

    assign sda = ~(m_low | dut_oe);

    always #2.5 clk = ~clk;

    i2c_eeprom_slave #(.PROG_CYCLES(PROG)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda),
        .sda_oe (dut_oe),
        .dev_sel(SEL),
        .lock_hi(lock)
    );

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    int t_stop = -100000;
    int ptr = 0;
    logic [7:0] model [256];
    bit m_owns = 1'b0;
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock monitors, sampled away from both edges
    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            if (m_owns && dut_oe) check(1'b0, "R9 block drives during master bit", 1, 0);
            if (scl && prev_scl && dut_oe !== prev_oe)
                check(1'b0, "R10 data line moved with clock high", int'(dut_oe), int'(prev_oe));
        end
        prev_scl = scl;
        prev_oe  = dut_oe;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; idle(Q);
        scl = 1'b1;   idle(Q);
        m_low = 1'b1; idle(Q);
        scl = 1'b0;   idle(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; idle(Q);
        scl = 1'b1;   idle(Q);
        m_low = 1'b0; idle(Q);
    endtask

    task automatic put_bit(input bit b);
        m_low = !b; m_owns = 1'b1; idle(Q);
        scl = 1'b1; idle(2*Q);
        scl = 1'b0; m_owns = 1'b0; idle(Q);
    endtask

    task automatic get_bit(output bit b);
        m_low = 1'b0; idle(Q);
        scl = 1'b1;   idle(Q);
        b = sda;      idle(Q);
        scl = 1'b0;   idle(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    task automatic wr_txn(input int word, input int n, input int base);
        bit a;
        logic [7:0] d;
        bus_start();
        send_byte(DEVW, a);
        check(a, "R2 own address acked for write", int'(a), 1);
        send_byte(8'(word), a);
        check(a, "R3 word address acked", int'(a), 1);
        ptr = word;
        for (int i = 0; i < n; i++) begin
            d = 8'(base + i * 7);
            send_byte(d, a);
            check(a, "R3 R8 data byte acked", int'(a), 1);
            if (!(lock && ptr >= 128)) model[ptr] = d;
            ptr = (ptr & 8'hF0) | ((ptr + 1) & 8'h0F);
        end
        bus_stop();
        t_stop = cyc - Q;
    endtask

    task automatic poll_ready();
        bit a;
        int el;
        int tries = 0;
        for (int k = 0; k < 40; k++) begin
            bus_start();
            send_byte(DEVW, a);
            tries++;
            el = cyc - t_stop;
            if (el < PROG - 60)      check(!a, "R7 address refused while programming", int'(a), 0);
            else if (el > PROG + 60) check(a, "R7 address acked after programming", int'(a), 1);
            bus_stop();
            if (a) break;
        end
        check(tries > 1, "R7 busy window observed", tries, 2);
    endtask

    task automatic rd_body(input int n);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            check(v == model[ptr], "R5 R6 read byte", int'(v), int'(model[ptr]));
            ptr = (ptr + 1) & 8'hFF;
        end
        idle(2);
        check(dut_oe == 1'b0, "R6 line released after NACK", int'(dut_oe), 0);
        bus_stop();
    endtask

    task automatic rd_random(input int word, input int n);
        bit a;
        bus_start();
        send_byte(DEVW, a);
        check(a, "R5 address acked", int'(a), 1);
        send_byte(8'(word), a);
        check(a, "R5 word acked", int'(a), 1);
        ptr = word;
        bus_start();
        send_byte(DEVR, a);
        check(a, "R5 read address acked", int'(a), 1);
        rd_body(n);
    endtask

    task automatic rd_current(input int n);
        bit a;
        bus_start();
        send_byte(DEVR, a);
        check(a, "R5 current read address acked", int'(a), 1);
        rd_body(n);
    endtask

    initial begin
        bit a;
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        idle(5);
        check(dut_oe == 1'b0, "R1 line released in reset", int'(dut_oe), 0);
        rst_n = 1'b1;
        idle(10);
        check(dut_oe == 1'b0, "R1 line released after reset", int'(dut_oe), 0);
        rd_random(8'h44, 1);

        // R2: wrong strap bits, then wrong type code
        bus_start();
        send_byte(8'hA6, a);
        check(!a, "R2 foreign strap address refused", int'(a), 0);
        send_byte(8'h44, a);
        check(!a, "R2 silent after refusal", int'(a), 0);
        bus_stop();
        bus_start();
        send_byte(8'hBA, a);
        check(!a, "R2 foreign type code refused", int'(a), 0);
        bus_stop();

        // R3 byte write
        wr_txn(8'h10, 1, 8'hA5);
        poll_ready();
        rd_random(8'h10, 1);

        // R4 page write with wrap and overwrite
        wr_txn(8'h25, 18, 8'h30);
        poll_ready();
        rd_random(8'h20, 16);

        // R5 current-address read continues at 0x30
        rd_current(2);

        // R8 upper half locked, lower half writable
        lock = 1'b1;
        wr_txn(8'h80, 1, 8'h55);
        poll_ready();
        wr_txn(8'h7F, 1, 8'h22);
        poll_ready();
        lock = 1'b0;
        rd_random(8'h7F, 2);

        // R6 sequential read wrapping through 0xFF
        wr_txn(8'hFE, 2, 8'h90);
        poll_ready();
        wr_txn(8'h00, 1, 8'h3C);
        poll_ready();
        rd_random(8'hFD, 5);

        idle(20);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule